// File: doc/BRIEF.md
# Parallel Port Readout Interface

This block presents a byte-wide data bus to a host parallel port. The host chooses what appears on the bus with two control lines. The choices are the stored sample stream of channel A, the stored sample stream of channel B, a mailbox byte, or a constant identification byte. The host can check the identification byte to confirm the device is present before it starts any other traffic.

Sample memory is read through a readout pointer. Each rising edge of the host strobe moves the pointer forward by one. The strobe arrives asynchronously and is brought into the local clock domain by a synchronizer. A prepare pulse from the local controller returns the pointer to the start of the readout window. Past the last address of the window, the pointer wraps back to the start.

In scroll mode, the two channel selections return the live converter bytes instead of memory contents. The block also drives the enable for the data bus. When the host marks the port as host-driven, the enable is dropped and the data bus is forced to zero.

Top module: `pport_readout`

## Requirements
- R1: After synchronous reset, `mem_addr_o` is 0x4000, `data_oe_o` is 0 and `data_o` is 0x00.
- R2: The select code is {`sel_aux_i`,`sel_alt_i`}. Code 00 drives memory A data, 01 drives memory B data, 10 drives `mbox_i`, and 11 drives the constant 0x55. `data_o` is registered: it reflects the selection one clock after the memory read data.
- R3: While `scroll_i` is 1, code 00 drives `live_a_i` and code 01 drives `live_b_i` instead of memory data. Codes 10 and 11 are unchanged.
- R4: Each rising edge of `host_strobe_i` advances `mem_addr_o` by exactly one, after a two-flop synchronizer. Holding the strobe high or low causes no further movement.
- R5: A one-cycle `prep_i` pulse sets `mem_addr_o` to 0x4000. It takes priority over a strobe edge detected in the same cycle.
- R6: When the pointer is at 0x7FFF, the next strobe edge sets it to 0x4000. The pointer never leaves the window 0x4000..0x7FFF.
- R7: While `host_dir_i` is 1 (host-driven), the next clock gives `data_oe_o` = 0 and `data_o` = 0x00. While `host_dir_i` is 0, `data_oe_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_alt_i | input | 1 | Select line, bit 0 of the select code |
| sel_aux_i | input | 1 | Select line, bit 1 of the select code |
| host_strobe_i | input | 1 | Asynchronous host strobe; a rising edge advances the pointer |
| host_dir_i | input | 1 | 1 = host drives the data bus |
| prep_i | input | 1 | Readout-prepare pulse; resets the pointer |
| scroll_i | input | 1 | Scroll mode; channel selections return live bytes |
| mbox_i | input | 8 | Mailbox byte |
| live_a_i | input | 8 | Live converter byte, channel A |
| live_b_i | input | 8 | Live converter byte, channel B |
| mem_addr_o | output | 15 | Readout address into sample memory |
| mem_a_i | input | 8 | Memory A read data (one-cycle read latency) |
| mem_b_i | input | 8 | Memory B read data (one-cycle read latency) |
| data_o | output | 8 | Byte presented to the host |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
A wrong pointer value shows up on `mem_addr_o` in the very next cycle. It also changes the memory byte on `data_o` two cycles later. The error then persists across every following strobe until a prepare pulse, so a single pointer slip shows in every later sample check. A wrong synchronizer or edge-detector state shows up as skipped or doubled steps a few cycles after a strobe edge. The long run through the whole window exposes a bad wrap within one strobe of 0x7FFF.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    SRC_CHA  = 2'b00,
    SRC_CHB  = 2'b01,
    SRC_MBOX = 2'b10,
    SRC_ID   = 2'b11
  } src_e;
endpackage

// File: rtl/rp_strobe_sync.sv
module rp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~last_q;

  // R4: one pulse per edge, never two in a row
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/rp_read_ptr.sv
module rp_read_ptr #(
  parameter int              ADDR_W   = 15,
  parameter logic [ADDR_W-1:0] WIN_BASE = 15'h4000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 15'h7FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              prep_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic at_last;
  assign at_last = (ptr_o == WIN_LAST);

  always_ff @(posedge clk) begin
    if (rst || prep_i)  ptr_o <= WIN_BASE;
    else if (step_i)    ptr_o <= at_last ? WIN_BASE : ptr_o + 1'b1;
  end

  p_prep_base_r5: assert property (@(posedge clk) disable iff (rst)
    prep_i |=> ptr_o == WIN_BASE);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!prep_i && !step_i) |=> $stable(ptr_o));
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (step_i && !prep_i && ptr_o == WIN_LAST) |=> ptr_o == WIN_BASE);
  p_in_window_r6: assert property (@(posedge clk) disable iff (rst)
    ptr_o >= WIN_BASE);
endmodule

// File: rtl/rp_out_mux.sv
module rp_out_mux
  import rp_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] ID_BYTE = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  src_e              src_i,
  input  logic              scroll_i,
  input  logic              host_dir_i,
  input  logic [DATA_W-1:0] mem_a_i,
  input  logic [DATA_W-1:0] mem_b_i,
  input  logic [DATA_W-1:0] live_a_i,
  input  logic [DATA_W-1:0] live_b_i,
  input  logic [DATA_W-1:0] mbox_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    unique case (src_i)
      SRC_CHA:  pick = scroll_i ? live_a_i : mem_a_i;
      SRC_CHB:  pick = scroll_i ? live_b_i : mem_b_i;
      SRC_MBOX: pick = mbox_i;
      default:  pick = ID_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      data_oe_o <= ~host_dir_i;
      data_o    <= host_dir_i ? '0 : pick;
    end
  end

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    host_dir_i |=> (!data_oe_o && data_o == '0));
  p_id_byte_r2: assert property (@(posedge clk) disable iff (rst)
    (src_i == SRC_ID && !host_dir_i) |=> (data_oe_o && data_o == ID_BYTE));
  p_mbox_r2: assert property (@(posedge clk) disable iff (rst)
    (src_i == SRC_MBOX && !host_dir_i) |=> data_o == $past(mbox_i));
endmodule

// File: rtl/pport_readout.sv
module pport_readout
  import rp_pkg::*;
#(
  parameter int              ADDR_W      = 15,
  parameter int              DATA_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 15'h4000,
  parameter logic [ADDR_W-1:0] WIN_LAST    = 15'h7FFF,
  parameter logic [DATA_W-1:0] ID_BYTE     = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_alt_i,
  input  logic              sel_aux_i,
  input  logic              host_strobe_i,
  input  logic              host_dir_i,
  input  logic              prep_i,
  input  logic              scroll_i,
  input  logic [DATA_W-1:0] mbox_i,
  input  logic [DATA_W-1:0] live_a_i,
  input  logic [DATA_W-1:0] live_b_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_a_i,
  input  logic [DATA_W-1:0] mem_b_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic step;
  src_e src;

  assign src = src_e'({sel_aux_i, sel_alt_i});

  rp_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_i(host_strobe_i), .rise_o(step)
  );

  rp_read_ptr #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) ptr_i (
    .clk(clk), .rst(rst), .step_i(step), .prep_i(prep_i), .ptr_o(mem_addr_o)
  );

  rp_out_mux #(.DATA_W(DATA_W), .ID_BYTE(ID_BYTE)) mux_i (
    .clk(clk), .rst(rst), .src_i(src), .scroll_i(scroll_i),
    .host_dir_i(host_dir_i), .mem_a_i(mem_a_i), .mem_b_i(mem_b_i),
    .live_a_i(live_a_i), .live_b_i(live_b_i), .mbox_i(mbox_i),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );
endmodule

// File: tb/pport_readout_tb_top.sv
module pport_readout_tb_top;
  localparam logic [14:0] BASE = 15'h4000;
  localparam logic [14:0] LAST = 15'h7FFF;

  logic clk = 0;
  logic rst = 1;
  logic sel_alt = 0, sel_aux = 0, strobe = 0, hdir = 0, prep = 0, scroll = 0;
  logic [7:0] mbox = 0, live_a = 0, live_b = 0, mem_a, mem_b, data;
  logic [14:0] addr;
  logic oe;
  int n_run = 0, n_fail = 0;
  logic [14:0] exp_ptr;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] fa(logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1};
  endfunction
  function automatic logic [7:0] fb(logic [14:0] a);
    return ~a[7:0] + a[14:7];
  endfunction

  always_ff @(posedge clk) begin
    mem_a <= fa(addr);
    mem_b <= fb(addr);
  end

  pport_readout dut_i (
    .clk(clk), .rst(rst), .sel_alt_i(sel_alt), .sel_aux_i(sel_aux),
    .host_strobe_i(strobe), .host_dir_i(hdir), .prep_i(prep), .scroll_i(scroll),
    .mbox_i(mbox), .live_a_i(live_a), .live_b_i(live_b), .mem_addr_o(addr),
    .mem_a_i(mem_a), .mem_b_i(mem_b), .data_o(data), .data_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data();
    if (hdir) return 8'h00;
    case ({sel_aux, sel_alt})
      2'b00: return scroll ? live_a : fa(exp_ptr);
      2'b01: return scroll ? live_b : fb(exp_ptr);
      2'b10: return mbox;
      default: return 8'h55;
    endcase
  endfunction

  task automatic pulse_strobe();
    strobe = 1;
    repeat (3) @(negedge clk);
    strobe = 0;
    repeat (3) @(negedge clk);
    exp_ptr = (exp_ptr == LAST) ? BASE : exp_ptr + 15'd1;
  endtask

  task automatic pulse_prep();
    prep = 1;
    @(negedge clk);
    prep = 0;
    repeat (3) @(negedge clk);
    exp_ptr = BASE;
  endtask

  task automatic check_all(input string req);
    chk(addr == exp_ptr, {req, " addr"}, addr, exp_ptr);
    chk(data == exp_data(), {req, " data"}, data, exp_data());
    chk(oe == !hdir, {req, " oe"}, oe, !hdir);
  endtask

  initial begin
    void'($urandom(32'd7));
    exp_ptr = BASE;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(addr == BASE, "R1 addr", addr, BASE);
    chk(oe == 0, "R1 oe", oe, 0);
    chk(data == 0, "R1 data", data, 0);
    rst = 0;
    repeat (3) @(negedge clk);

    // R2: the four selection codes
    mbox = 8'hA7;
    for (int c = 0; c < 4; c++) begin
      {sel_aux, sel_alt} = c[1:0];
      repeat (3) @(negedge clk);
      check_all("R2");
    end
    // R3: scroll mode returns live bytes
    scroll = 1; live_a = 8'h3C; live_b = 8'hC3;
    for (int c = 0; c < 2; c++) begin
      {sel_aux, sel_alt} = c[1:0];
      repeat (3) @(negedge clk);
      check_all("R3");
    end
    scroll = 0;
    // R4: a held strobe advances exactly once
    strobe = 1;
    repeat (10) @(negedge clk);
    chk(addr == BASE + 15'd1, "R4 held", addr, BASE + 15'd1);
    strobe = 0;
    repeat (10) @(negedge clk);
    chk(addr == BASE + 15'd1, "R4 low", addr, BASE + 15'd1);
    exp_ptr = BASE + 15'd1;
    // R5: prepare coinciding with a detected strobe edge wins
    strobe = 1;
    @(negedge clk); @(negedge clk);
    prep = 1;
    @(negedge clk);
    prep = 0;
    repeat (4) @(negedge clk);
    strobe = 0;
    repeat (4) @(negedge clk);
    exp_ptr = BASE;
    chk(addr == BASE, "R5 coincident", addr, BASE);
    // R7: host-driven releases the bus
    hdir = 1; {sel_aux, sel_alt} = 2'b11;
    repeat (2) @(negedge clk);
    check_all("R7");
    hdir = 0;

    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      {sel_aux, sel_alt} = 2'($urandom);
      scroll = ($urandom % 4) == 0;
      hdir   = ($urandom % 6) == 0;
      mbox = 8'($urandom); live_a = 8'($urandom); live_b = 8'($urandom);
      case ($urandom % 4)
        0, 1: pulse_strobe();
        2:    pulse_prep();
        default: repeat (3) @(negedge clk);
      endcase
      check_all("R2/R3/R4/R5 random");
    end

    // R6: walk the whole window and wrap
    hdir = 0; scroll = 0; {sel_aux, sel_alt} = 2'b00;
    pulse_prep();
    for (int i = 0; i < 16383; i++) pulse_strobe();
    chk(addr == LAST, "R6 last", addr, LAST);
    check_all("R6");
    pulse_strobe();
    chk(addr == BASE, "R6 wrap", addr, BASE);
    check_all("R6");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule